// File: doc/BRIEF.md
# Single-Shot Codec Command Port

This block provides a one-command-at-a-time path from software to an audio codec, for use where no command/response ring is set up. Software sees three word registers on a simple write/read bus: a command word, a response word and a status word holding two flags. The first flag, busy, is set by software and cleared by hardware. The second flag, valid, is set by hardware and cleared when software writes a one to it.

The usual software sequence runs as follows. Poll until busy reads 0. Write 1 to the valid flag to clear it. Write the command word, then set busy. The block presents the command on a request/ready handshake toward the codec. It drops busy once the codec has accepted the command. It then waits for one reply on the response port. When the reply arrives, the block stores it and raises valid on the same clock edge. Software polls valid a bounded number of times and then reads the response word.

The block models only the register decode and the handshake toward a simple codec port. The serial link beyond that port is not part of it.

Top module: `imm_cmd_ctrl`

## Requirements
- R1: After a synchronous reset, busy and valid are 0. The command and response words read 0, and `codec_req_valid` is low.
- R2: Word addresses are 0 for the command, 1 for the response and 2 for the status. A bus write to address 0 while busy is 0 stores `bus_wdata` as the command. The stored value reads back at address 0 from the next cycle.
- R3: A write to the command word while busy is 1 is ignored. The stored command and `codec_cmd` keep their value.
- R4: Writing status with bit 0 = 1 sets busy on that edge. While busy is 1 and no reply is outstanding, `codec_req_valid` is high and `codec_cmd` equals the stored command.
- R5: On the edge where `codec_req_valid` and `codec_req_ready` are both high, busy clears and the request drops. While ready stays low, the request and its command stay unchanged.
- R6: After acceptance, the first `codec_rsp_valid` loads `codec_rsp_data` into the response word and sets valid on the same edge.
- R7: Writing status with bit 1 = 1 clears valid, and bit 1 = 0 leaves it unchanged. If a reply is captured on the same edge as the clear, valid ends up 1.
- R8: Status writes cannot clear busy. A second set of busy while busy is already 1 has no effect, so one set yields exactly one accepted transfer.
- R9: A `codec_rsp_valid` that arrives while no accepted command awaits a reply is ignored. The response word and valid are left unchanged.
- R10: A command started while the previous reply is still outstanding is not presented to the codec until that reply has been captured.
- R11: Status bits 15..2 and all upper bits of the read word read 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 command, 1 response, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| codec_req_valid | output | 1 | Command offered to the codec |
| codec_req_ready | input | 1 | Codec accepts the offered command |
| codec_cmd | output | 32 | Command word toward the codec |
| codec_rsp_valid | input | 1 | Codec reply strobe |
| codec_rsp_data | input | 32 | Codec reply word |

## Verification
Read data is combinational, so a register write made before an edge is visible at the following falling edge. Setting busy raises `codec_req_valid` after that same single edge. The clearing of busy, and the storing of a reply together with valid, each show up after exactly one edge following the qualifying handshake cycle. The bench drives every input at a falling edge and samples at the next falling edge, one register stage later. Its waiting loops check that the request stays steady and that valid stays low until the handshake it is waiting for.

// File: rtl/imm_cmd_pkg.sv
package imm_cmd_pkg;

    localparam int unsigned REG_AW = 2;
    localparam int unsigned STAT_W = 16;

    localparam logic [REG_AW-1:0] ADDR_CMD  = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_RESP = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_STAT = 2'd2;

    localparam int unsigned BIT_BUSY  = 0;
    localparam int unsigned BIT_VALID = 1;

    typedef enum logic {
        LNK_IDLE  = 1'b0,
        LNK_AWAIT = 1'b1
    } link_state_e;

    typedef struct packed {
        logic valid;
        logic busy;
    } stat_flags_t;

    function automatic logic [STAT_W-1:0] pack_status(stat_flags_t f);
        logic [STAT_W-1:0] w;
        w = '0;
        w[BIT_BUSY]  = f.busy;
        w[BIT_VALID] = f.valid;
        return w;
    endfunction

endpackage

// File: rtl/imm_cmd_regs.sv
module imm_cmd_regs
    import imm_cmd_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              hw_clr_busy,
    input  logic              hw_capture,
    input  logic [DATA_W-1:0] hw_resp,
    output logic [DATA_W-1:0] cmd_o,
    output logic [DATA_W-1:0] resp_o,
    output stat_flags_t       flags_o,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int unsigned PAD_W = DATA_W - STAT_W;

    logic [DATA_W-1:0] cmd_q, resp_q;
    stat_flags_t       flags_q;
    logic              wr_cmd, wr_stat, set_busy, clr_valid;

    assign wr_cmd    = bus_wr && (bus_addr == ADDR_CMD) && !flags_q.busy;
    assign wr_stat   = bus_wr && (bus_addr == ADDR_STAT);
    assign set_busy  = wr_stat && bus_wdata[BIT_BUSY] && !flags_q.busy;
    assign clr_valid = wr_stat && bus_wdata[BIT_VALID];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            resp_q  <= '0;
            flags_q <= '0;
        end else begin
            if (wr_cmd) cmd_q <= bus_wdata;
            if (set_busy)         flags_q.busy <= 1'b1;
            else if (hw_clr_busy) flags_q.busy <= 1'b0;
            if (hw_capture) begin
                resp_q        <= hw_resp;
                flags_q.valid <= 1'b1;
            end else if (clr_valid) begin
                flags_q.valid <= 1'b0;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CMD:  bus_rdata = cmd_q;
            ADDR_RESP: bus_rdata = resp_q;
            ADDR_STAT: bus_rdata = {{PAD_W{1'b0}}, pack_status(flags_q)};
            default:   bus_rdata = '0;
        endcase
    end

    assign cmd_o   = cmd_q;
    assign resp_o  = resp_q;
    assign flags_o = flags_q;
endmodule

// File: rtl/imm_cmd_link.sv
module imm_cmd_link
    import imm_cmd_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic [DATA_W-1:0] cmd,
    output logic              hw_clr_busy,
    output logic              hw_capture,
    output logic [DATA_W-1:0] hw_resp,
    output logic              awaiting,
    output logic              codec_req_valid,
    input  logic              codec_req_ready,
    output logic [DATA_W-1:0] codec_cmd,
    input  logic              codec_rsp_valid,
    input  logic [DATA_W-1:0] codec_rsp_data
);
    link_state_e state_q;

    assign codec_req_valid = busy && (state_q == LNK_IDLE);
    assign codec_cmd       = cmd;
    assign hw_clr_busy     = codec_req_valid && codec_req_ready;
    assign hw_capture      = (state_q == LNK_AWAIT) && codec_rsp_valid;
    assign hw_resp         = codec_rsp_data;
    assign awaiting        = (state_q == LNK_AWAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LNK_IDLE;
        end else begin
            case (state_q)
                LNK_IDLE:  if (hw_clr_busy) state_q <= LNK_AWAIT;
                LNK_AWAIT: if (hw_capture)  state_q <= LNK_IDLE;
                default:   state_q <= LNK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/imm_cmd_ctrl.sv
module imm_cmd_ctrl
    import imm_cmd_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              codec_req_valid,
    input  logic              codec_req_ready,
    output logic [DATA_W-1:0] codec_cmd,
    input  logic              codec_rsp_valid,
    input  logic [DATA_W-1:0] codec_rsp_data
);
    logic [DATA_W-1:0] cmd_w, resp_w, hw_resp_w;
    stat_flags_t       flags_w;
    logic              clr_busy_w, capture_w, awaiting_w;
    logic              sts_busy, sts_valid;

    imm_cmd_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .hw_clr_busy (clr_busy_w),
        .hw_capture  (capture_w),
        .hw_resp     (hw_resp_w),
        .cmd_o       (cmd_w),
        .resp_o      (resp_w),
        .flags_o     (flags_w),
        .bus_rdata   (bus_rdata)
    );

    imm_cmd_link #(.DATA_W(DATA_W)) u_link (
        .clk             (clk),
        .rst             (rst),
        .busy            (flags_w.busy),
        .cmd             (cmd_w),
        .hw_clr_busy     (clr_busy_w),
        .hw_capture      (capture_w),
        .hw_resp         (hw_resp_w),
        .awaiting        (awaiting_w),
        .codec_req_valid (codec_req_valid),
        .codec_req_ready (codec_req_ready),
        .codec_cmd       (codec_cmd),
        .codec_rsp_valid (codec_rsp_valid),
        .codec_rsp_data  (codec_rsp_data)
    );

    assign sts_busy  = flags_w.busy;
    assign sts_valid = flags_w.valid;
endmodule

// File: rtl/imm_cmd_checker.sv
module imm_cmd_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              codec_req_valid,
    input logic              codec_req_ready,
    input logic [DATA_W-1:0] codec_cmd,
    input logic              codec_rsp_valid,
    input logic [DATA_W-1:0] codec_rsp_data,
    input logic              busy,
    input logic              valid,
    input logic [DATA_W-1:0] resp,
    input logic              awaiting
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !busy && !valid && !codec_req_valid);

    assert_cmd_locked_R3: assert property (@(posedge clk) disable iff (rst)
        busy && bus_wr && bus_addr == 2'd0 |=> $stable(codec_cmd));

    assert_req_held_R5: assert property (@(posedge clk) disable iff (rst)
        codec_req_valid && !codec_req_ready |=> codec_req_valid && $stable(codec_cmd));

    assert_busy_drop_R5: assert property (@(posedge clk) disable iff (rst)
        codec_req_valid && codec_req_ready |=> !busy && !codec_req_valid);

    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        awaiting && codec_rsp_valid |=> valid && resp == $past(codec_rsp_data));

    assert_valid_clear_R7: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == 2'd2 && bus_wdata[1] && !(awaiting && codec_rsp_valid)
        |=> !valid);

    assert_stray_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        !awaiting && codec_rsp_valid |=> $stable(resp));

    assert_no_req_waiting_R10: assert property (@(posedge clk) disable iff (rst)
        awaiting |-> !codec_req_valid);
endmodule

bind imm_cmd_ctrl imm_cmd_checker #(.DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .codec_req_valid (codec_req_valid),
    .codec_req_ready (codec_req_ready),
    .codec_cmd       (codec_cmd),
    .codec_rsp_valid (codec_rsp_valid),
    .codec_rsp_data  (codec_rsp_data),
    .busy            (sts_busy),
    .valid           (sts_valid),
    .resp            (resp_w),
    .awaiting        (awaiting_w)
);

// File: tb/test_imm_cmd_ctrl.sv
module test_imm_cmd_ctrl;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        codec_req_valid;
    logic        codec_req_ready = 1'b0;
    logic [31:0] codec_cmd;
    logic        codec_rsp_valid = 1'b0;
    logic [31:0] codec_rsp_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    imm_cmd_ctrl i_imm_cmd_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .codec_req_valid(codec_req_valid), .codec_req_ready(codec_req_ready),
        .codec_cmd(codec_cmd), .codec_rsp_valid(codec_rsp_valid),
        .codec_rsp_data(codec_rsp_data)
    );

    function automatic logic [31:0] exp_status(bit b, bit v);
        return {30'd0, v, b};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_reg(string req, logic [1:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic accept_after(int dly);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check("R5 request held", {31'd0, codec_req_valid}, 32'd1);
        end
        @(negedge clk); codec_req_ready = 1'b1;
        @(negedge clk); codec_req_ready = 1'b0;
        check("R5 request dropped", {31'd0, codec_req_valid}, 32'd0);
        chk_reg("R5 busy cleared", 2'd2, exp_status(0, 0));
    endtask

    task automatic reply_after(int dly, logic [31:0] r);
        for (int i = 0; i < dly; i++) @(negedge clk);
        chk_reg("R6 valid low before reply", 2'd2, exp_status(0, 0));
        @(negedge clk); codec_rsp_valid = 1'b1; codec_rsp_data = r;
        @(negedge clk); codec_rsp_valid = 1'b0; codec_rsp_data = ~r;
        chk_reg("R6 response word", 2'd1, r);
        chk_reg("R6 valid set", 2'd2, exp_status(0, 1));
    endtask

    task automatic transact(logic [31:0] c, logic [31:0] r, int d1, int d2);
        wr(2'd2, 32'h2);
        chk_reg("R7 valid cleared", 2'd2, exp_status(0, 0));
        wr(2'd0, c);
        chk_reg("R2 command stored", 2'd0, c);
        wr(2'd2, 32'h1);
        chk_reg("R4 busy set", 2'd2, exp_status(1, 0));
        check("R4 request raised", {31'd0, codec_req_valid}, 32'd1);
        check("R4 command presented", codec_cmd, c);
        accept_after(d1);
        reply_after(d2, r);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] c, r;
        void'($urandom(32'h1A2B3C));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_reg("R1 status", 2'd2, exp_status(0, 0));
        chk_reg("R1 command", 2'd0, 32'd0);
        chk_reg("R1 response", 2'd1, 32'd0);
        check("R1 request low", {31'd0, codec_req_valid}, 32'd0);
        // R11 unused address and high bits
        wr(2'd2, 32'hFFFF_FFFC);
        chk_reg("R11 status high bits", 2'd2, 32'd0);
        chk_reg("R11 address 3", 2'd3, 32'd0);
        // directed transaction with zero delays
        transact(32'h1234_5678, 32'h8765_4321, 0, 0);
        // R7 bit1 = 0 leaves valid
        wr(2'd2, 32'h0);
        chk_reg("R7 valid kept", 2'd2, exp_status(0, 1));
        // R9 stray reply ignored
        @(negedge clk); codec_rsp_valid = 1'b1; codec_rsp_data = 32'hDEAD_BEEF;
        @(negedge clk); codec_rsp_valid = 1'b0;
        chk_reg("R9 response unchanged", 2'd1, 32'h8765_4321);
        chk_reg("R9 valid unchanged", 2'd2, exp_status(0, 1));
        // R3 and R8: command locked, busy cannot be cleared or re-set
        wr(2'd2, 32'h2);
        wr(2'd0, 32'hAAAA_0001);
        wr(2'd2, 32'h1);
        wr(2'd0, 32'hBBBB_0002);
        chk_reg("R3 command locked", 2'd0, 32'hAAAA_0001);
        check("R3 codec command", codec_cmd, 32'hAAAA_0001);
        wr(2'd2, 32'h0);
        chk_reg("R8 busy not cleared by write", 2'd2, exp_status(1, 0));
        wr(2'd2, 32'h1);
        accept_after(1);
        repeat (3) begin
            @(negedge clk);
            check("R8 single transfer per set", {31'd0, codec_req_valid}, 32'd0);
        end
        // R10 new command issued while reply outstanding
        wr(2'd0, 32'hCCCC_0003);
        wr(2'd2, 32'h1);
        chk_reg("R10 busy set while waiting", 2'd2, exp_status(1, 0));
        check("R10 request withheld", {31'd0, codec_req_valid}, 32'd0);
        // R7 clear and capture on the same edge: capture wins
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h2;
        codec_rsp_valid = 1'b1; codec_rsp_data = 32'h5555_AAAA;
        @(negedge clk);
        bus_wr = 1'b0; codec_rsp_valid = 1'b0;
        chk_reg("R7 capture beats clear", 2'd2, exp_status(1, 1));
        chk_reg("R6 response on simultaneous", 2'd1, 32'h5555_AAAA);
        check("R10 request after reply", {31'd0, codec_req_valid}, 32'd1);
        check("R10 pending command", codec_cmd, 32'hCCCC_0003);
        wr(2'd2, 32'h2);
        accept_after(0);
        reply_after(1, 32'h0F0F_0F0F);
        // random transactions
        for (int k = 0; k < 40; k++) begin
            c = $urandom; r = $urandom;
            transact(c, r, int'($urandom_range(0, 5)), int'($urandom_range(0, 6)));
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule